// File: doc/BRIEF.md
# Strip-Mined Vector Length Sequencer

This block splits an application vector of any length `n` into pieces that a machine with a fixed maximum vector length `MVL` can process. After a start pulse it presents one piece at a time, giving the index of the piece's first element and the number of elements in it. Element processing, memory traffic and loop-overhead accounting are left to other units.

The odd-sized piece (`n mod MVL`) is always presented first. Every piece after it has exactly `MVL` elements. If the remainder is zero, no empty piece is produced and the first piece already has full length. A downstream unit takes each piece with a valid/ready handshake, so it can stall the sequence between pieces. When the last piece has been taken, a one-cycle done pulse follows. When `n` is zero, the done pulse follows the start pulse directly.

Top module: `strip_seq`

## Requirements
- R1: After reset, `pc_valid` and `done` are both low.
- R2: When `n mod MVL` is not zero, the first piece has start index 0 and length `n mod MVL`.
- R3: Every piece other than a nonzero remainder piece has length `MVL`. When the remainder is zero, the first piece has start index 0 and length `MVL`.
- R4: The start index of each piece after the first equals the previous piece's start index plus the previous piece's length.
- R5: Exactly `floor(n/MVL)` pieces are issued, plus one more when `n mod MVL` is not zero. A zero-length piece is never issued.
- R6: When `n` is zero, `done` is high in the cycle after the start pulse is sampled, and no piece is issued.
- R7: While `pc_valid` is high and `pc_ready` is low, `pc_valid` stays high and `pc_base` and `pc_len` hold their values. A piece is handed over only on a clock edge where both `pc_valid` and `pc_ready` are high.
- R8: In the cycle after the last piece is accepted, `done` is high and `pc_valid` is low. `done` is high for one cycle only.
- R9: A start pulse that arrives while pieces are still being issued is ignored. The sequence in progress continues unchanged.
- R10: Whenever `pc_valid` is high, `pc_len` lies between 1 and `MVL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; sampled only when no sequence is running |
| total_len | input | NW | Application vector length `n`, sampled with `start` |
| pc_ready | input | 1 | Downstream can accept the current piece |
| pc_valid | output | 1 | A piece is being presented |
| pc_base | output | NW | Index of the piece's first element |
| pc_len | output | LW | Number of elements in the piece (LW = clog2(MVL+1)) |
| done | output | 1 | One-cycle pulse when the whole vector has been handed over |

## Verification
The assertions check the following on every cycle:
- the piece length stays in range;
- a stalled piece holds its values;
- each piece after an accepted one has full length and a start index advanced by the previous length;
- done is a single-cycle pulse that never overlaps a valid piece.

Only the bench's scenarios can show two further properties. The first is that the remainder piece really comes first with the right size, and that a zero remainder or a zero length is handled. The second is that the total piece count matches the length and that a start pulse arriving mid-sequence leaves that sequence untouched.

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int MVL = 64,
  parameter int NW  = 16,
  localparam int LW = $clog2(MVL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] total_len,
  input  logic          pc_ready,
  output logic          pc_valid,
  output logic [NW-1:0] pc_base,
  output logic [LW-1:0] pc_len,
  output logic          done
);

  localparam logic [NW-1:0] MVL_N = NW'(MVL);
  localparam logic [LW-1:0] MVL_L = LW'(MVL);

  logic          busy_q;
  logic          done_q;
  logic [NW-1:0] base_q;
  logic [LW-1:0] len_q;
  logic [NW-1:0] left_q;

  logic [NW-1:0] rem_w;
  logic [NW-1:0] quo_w;
  logic          take;
  logic          accept;

  assign rem_w  = total_len % MVL_N;
  assign quo_w  = total_len / MVL_N;
  assign take   = start && !busy_q;
  assign accept = busy_q && pc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      base_q <= '0;
      len_q  <= '0;
      left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        base_q <= '0;
        if (rem_w != '0) begin
          busy_q <= 1'b1;
          len_q  <= LW'(rem_w);
          left_q <= quo_w;
        end else if (quo_w != '0) begin
          busy_q <= 1'b1;
          len_q  <= MVL_L;
          left_q <= quo_w - 1'b1;
        end else begin
          done_q <= 1'b1;
        end
      end else if (accept) begin
        if (left_q != '0) begin
          base_q <= base_q + NW'(len_q);
          len_q  <= MVL_L;
          left_q <= left_q - 1'b1;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign pc_valid = busy_q;
  assign pc_base  = base_q;
  assign pc_len   = len_q;
  assign done     = done_q;

endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
  parameter int MVL = 64,
  parameter int NW  = 16,
  parameter int LW  = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pc_ready,
  input logic          pc_valid,
  input logic [NW-1:0] pc_base,
  input logic [LW-1:0] pc_len,
  input logic          done
);

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> (pc_len != '0 && int'(pc_len) <= MVL)); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid && !pc_ready) |=> (pc_valid && $stable(pc_base) && $stable(pc_len))); // R7

  AST_FULL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid && pc_ready) |=> (!pc_valid || int'(pc_len) == MVL)); // R3

  AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid && pc_ready) |=> (!pc_valid || pc_base == $past(pc_base) + NW'($past(pc_len)))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pc_valid); // R8

endmodule

bind strip_seq strip_seq_chk #(.MVL(MVL), .NW(NW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_ready(pc_ready), .pc_valid(pc_valid),
  .pc_base(pc_base), .pc_len(pc_len), .done(done)
);

// File: tb/strip_seq_test.sv
`timescale 1ns/1ps
module strip_seq_test;
  localparam int MVL = 64;
  localparam int NW  = 16;
  localparam int LW  = $clog2(MVL + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NW-1:0] total_len = '0;
  logic          pc_ready = 1'b0;
  logic          pc_valid;
  logic [NW-1:0] pc_base;
  logic [LW-1:0] pc_len;
  logic          done;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  strip_seq #(.MVL(MVL), .NW(NW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
    .pc_ready(pc_ready), .pc_valid(pc_valid), .pc_base(pc_base),
    .pc_len(pc_len), .done(done)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input int n);
    return n / MVL + ((n % MVL) != 0 ? 1 : 0);
  endfunction

  function automatic int exp_len(input int n, input int k);
    if ((n % MVL) != 0 && k == 0) return n % MVL;
    return MVL;
  endfunction

  function automatic int exp_base(input int n, input int k);
    int r = n % MVL;
    if (r == 0) return k * MVL;
    if (k == 0) return 0;
    return r + (k - 1) * MVL;
  endfunction

  task automatic run_case(input int n, input bit poke, input int pct);
    int cnt = exp_count(n);
    int k = 0;
    int steps = 0;
    bit rdy;
    @(negedge clk);
    start = 1'b1;
    total_len = NW'(n);
    @(negedge clk);
    start = 1'b0;
    total_len = NW'($urandom);
    if (cnt == 0) begin
      chk(done == 1'b1, "R6 done after zero length", int'(done), 1);
      chk(pc_valid == 1'b0, "R6 no piece for zero length", int'(pc_valid), 0);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
      return;
    end
    while (k < cnt) begin
      chk(pc_valid == 1'b1, "R7 piece present", int'(pc_valid), 1);
      chk(done == 1'b0, "R8 no done mid-sequence", int'(done), 0);
      chk(int'(pc_base) == exp_base(n, k), (k == 0) ? "R2 first base" : (poke ? "R9 R4 base" : "R4 base"),
          int'(pc_base), exp_base(n, k));
      chk(int'(pc_len) == exp_len(n, k),
          (k == 0 && (n % MVL) != 0) ? "R2 remainder length" : (poke ? "R9 R3 length" : "R3 full length"),
          int'(pc_len), exp_len(n, k));
      rdy = (($urandom % 100) < pct);
      if (poke && steps == 1) begin
        start = 1'b1;
        total_len = NW'(($urandom % 300) + 1);
      end
      pc_ready = rdy;
      @(negedge clk);
      start = 1'b0;
      if (rdy) k++;
      steps++;
    end
    pc_ready = 1'b0;
    chk(done == 1'b1, "R5 R8 done after last piece", int'(done), 1);
    chk(pc_valid == 1'b0, "R5 no extra piece", int'(pc_valid), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    chk(pc_valid == 1'b0, "R5 stays idle", int'(pc_valid), 0);
  endtask

  initial begin
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk(pc_valid == 1'b0, "R1 reset valid", int'(pc_valid), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc_valid == 1'b0, "R1 idle after reset", int'(pc_valid), 0);

    run_case(0, 1'b0, 100);
    run_case(1, 1'b0, 100);
    run_case(63, 1'b0, 50);
    run_case(64, 1'b0, 100);
    run_case(65, 1'b0, 60);
    run_case(128, 1'b0, 30);
    run_case(129, 1'b0, 100);
    run_case(200, 1'b1, 40);
    run_case(64, 1'b1, 20);
    run_case(0, 1'b0, 50);
    for (int i = 0; i < 40; i++) begin
      int n = (($urandom % 4) == 0) ? int'(($urandom % 8) * MVL) : int'($urandom % 700);
      run_case(n, ($urandom % 3) == 0, 20 + int'($urandom % 80));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule